// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is a slave port that lets a host read and write a small bank of internal registers over three wires: an active-low select, a host-driven serial clock that idles high, and one data line that carries traffic in both directions. Every transaction opens with a command byte from the host naming a register and the direction. A second byte follows: on a write the host sends it, on a read the port answers with the register contents on the same line, turning the line around once the command byte is complete.

All three wires are brought into the core clock domain through a small synchronizer, and serial clock edges are detected there. The host must therefore hold each serial clock phase for several core clocks. Two registers feed the rest of the chip directly: one switches the microphone path, microphone source and the two speaker drivers, the other picks the transmit and receive gain modes and carries a self-clearing software reset. The second data pin is never driven.

Top module: `sio3_reg_port`

## Requirements
- R1: Bytes travel least significant bit first and are sampled on rising serial clock edges. In the command byte, bit 7 set means read, bits 4:0 give the register address, and bits 6:5 are ignored.
- R2: After a write command, the following byte is stored in the addressed register when its eighth bit is sampled, and any of the 32 registers reads back what was written.
- R3: After a read command, the port drives the register value least significant bit first. Bit 0 appears at the falling edge that follows the eighth rising edge, and each later bit appears at the next falling edge.
- R4: The output enable is low except during the eight data bit times of a read. It drops at the falling edge after the sixteenth rising edge, or as soon as select is released.
- R5: Releasing select before the sixteenth bit aborts the transaction with no register change, and the next transaction starts again from the first command bit.
- R6: Register 0x0E drives microphone enable (bit 0), microphone source select (bit 1), handset speaker enable (bit 2) and loudspeaker enable (bit 3).
- R7: Register 0x0F drives transmit gain mode (bit 0) and receive gain mode (bit 1).
- R8: Writing register 0x0F with bit 7 set returns every register, 0x0F included, to zero at the end of that transaction. Setting bit 7 in any other register is only a store.
- R9: After power-up reset all registers read zero and the data output enable is low. The second data pin's enable is held low at all times.
- R10: Serial clock edges beyond the sixteenth are ignored until select is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low power-up reset |
| cs_n | input | 1 | Active-low select from host |
| sclk | input | 1 | Host serial clock, idles high |
| sdata_in | input | 1 | Data line as seen at the pad |
| sdata_out | output | 1 | Value driven onto the data line |
| sdata_oe | output | 1 | Data line output enable |
| sdata2_oe | output | 1 | Second data pin enable, always low |
| mic_en | output | 1 | Microphone path enable |
| mic_sel | output | 1 | Microphone source select |
| hspk_en | output | 1 | Handset speaker enable |
| lspk_en | output | 1 | Loudspeaker enable |
| tx_gain_sel | output | 1 | Transmit gain mode |
| rx_gain_sel | output | 1 | Receive gain mode |

## Verification
Writes and reads are made to the two control registers and to addresses at both ends of the map. Some data bytes have alternating bit patterns, so that a reversed bit order or a bit slip shows up as a wrong value. Command bytes with the unused bits set show whether address decoding masks them. Select is released at several points: within the command byte, within the write data and within the read data. These cases separate a clean abort from a partial write and from a bit counter that carries stale state into the next transaction. Extra clocks after a full transaction, and software reset written both to its own register and to another register, tell a correctly bounded sequencer and an exact reset decode from sloppy ones.

// File: rtl/sio3_pkg.sv
package sio3_pkg;

  // Register addresses decoded by neighbouring logic
  localparam int unsigned XDCR_ADDR = 14;
  localparam int unsigned GCTL_ADDR = 15;

  // Transducer control bit positions
  localparam int unsigned XDCR_MIC_EN  = 0;
  localparam int unsigned XDCR_MIC_SEL = 1;
  localparam int unsigned XDCR_HSPK_EN = 2;
  localparam int unsigned XDCR_LSPK_EN = 3;

  // General control bit positions
  localparam int unsigned GCTL_TXG  = 0;
  localparam int unsigned GCTL_RXG  = 1;
  localparam int unsigned GCTL_SRST = 7;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_WDATA,
    PH_RDATA,
    PH_DONE
  } xfer_phase_e;

endpackage

// File: rtl/sio3_sync.sv
module sio3_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= RST_VAL;
        else        pipe[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= RST_VAL;
        else        pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/sio3_xfer.sv
module sio3_xfer
  import sio3_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5,
  localparam int CNT_W = $clog2(2*DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              din,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              dout,
  output logic              doe,
  output logic [CNT_W-1:0]  bit_cnt
);

  localparam logic [CNT_W-1:0] CNT_BYTE     = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_CMD_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] CNT_END      = CNT_W'(2*DATA_W);
  localparam logic [CNT_W-1:0] CNT_DAT_LAST = CNT_W'(2*DATA_W - 1);

  function automatic logic cmd_read(input logic [DATA_W-1:0] b);
    return b[DATA_W-1];
  endfunction

  function automatic logic [ADDR_W-1:0] cmd_addr(input logic [DATA_W-1:0] b);
    return b[ADDR_W-1:0];
  endfunction

  logic [DATA_W-1:0] rx_sr;
  logic [DATA_W-1:0] tx_sr;
  logic [DATA_W-1:0] rx_next;
  logic              cmd_rd;
  logic [ADDR_W-1:0] addr_q;
  logic              take_bit;
  logic              cmd_end;
  logic              data_end;
  xfer_phase_e       phase;

  assign rx_next  = {din, rx_sr[DATA_W-1:1]};
  assign take_bit = cs_act && sclk_rise && (bit_cnt < CNT_END);
  assign cmd_end  = take_bit && (bit_cnt == CNT_CMD_LAST);
  assign data_end = take_bit && (bit_cnt == CNT_DAT_LAST);
  assign wr_en    = data_end && !cmd_rd;
  assign wr_data  = rx_next;
  assign reg_addr = addr_q;

  always_comb begin
    if (bit_cnt < CNT_BYTE)      phase = PH_CMD;
    else if (bit_cnt == CNT_END) phase = PH_DONE;
    else if (cmd_rd)             phase = PH_RDATA;
    else                         phase = PH_WDATA;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      cmd_rd  <= 1'b0;
      addr_q  <= '0;
      dout    <= 1'b0;
      doe     <= 1'b0;
    end else if (!cs_act) begin
      bit_cnt <= '0;
      doe     <= 1'b0;
    end else begin
      if (take_bit) begin
        bit_cnt <= bit_cnt + 1'b1;
        rx_sr   <= rx_next;
        if (cmd_end) begin
          cmd_rd <= cmd_read(rx_next);
          addr_q <= cmd_addr(rx_next);
        end
      end
      if (sclk_fall) begin
        if (phase == PH_RDATA && bit_cnt == CNT_BYTE) begin
          doe   <= 1'b1;
          dout  <= rd_data[0];
          tx_sr <= rd_data >> 1;
        end else if (phase == PH_RDATA && doe) begin
          dout  <= tx_sr[0];
          tx_sr <= tx_sr >> 1;
        end else if (phase == PH_DONE) begin
          doe <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/sio3_regfile.sv
module sio3_regfile
  import sio3_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5,
  localparam int NREGS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] xdcr_q,
  output logic [DATA_W-1:0] gctl_q,
  output logic              srst_evt
);

  logic [DATA_W-1:0] regs [NREGS];

  assign srst_evt = wr_en && (addr == ADDR_W'(GCTL_ADDR)) && wr_data[GCTL_SRST];

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             regs[r] <= '0;
      else if (srst_evt)                      regs[r] <= '0;
      else if (wr_en && addr == ADDR_W'(r))   regs[r] <= wr_data;
    end
  end

  assign rd_data = regs[addr];
  assign xdcr_q  = regs[XDCR_ADDR];
  assign gctl_q  = regs[GCTL_ADDR];

endmodule

// File: rtl/sio3_reg_port.sv
module sio3_reg_port
  import sio3_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdata_in,
  output logic sdata_out,
  output logic sdata_oe,
  output logic sdata2_oe,
  output logic mic_en,
  output logic mic_sel,
  output logic hspk_en,
  output logic lspk_en,
  output logic tx_gain_sel,
  output logic rx_gain_sel
);

  localparam int CNT_W = $clog2(2*DATA_W + 1);

  logic [2:0]        pins_s;
  logic              cs_n_s, sclk_s, din_s;
  logic              sclk_prev;
  logic              cs_act, sclk_rise, sclk_fall;
  logic              wr_en, srst_evt;
  logic [ADDR_W-1:0] reg_addr;
  logic [DATA_W-1:0] wr_data, rd_data, xdcr_q, gctl_q;
  logic [CNT_W-1:0]  bit_cnt;

  sio3_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cs_n, sclk, sdata_in}),
    .q     (pins_s)
  );

  assign {cs_n_s, sclk_s, din_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b1;
    else        sclk_prev <= sclk_s;
  end

  assign cs_act    = !cs_n_s;
  assign sclk_rise = sclk_s && !sclk_prev;
  assign sclk_fall = !sclk_s && sclk_prev;

  sio3_xfer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_act    (cs_act),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .din       (din_s),
    .rd_data   (rd_data),
    .reg_addr  (reg_addr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .dout      (sdata_out),
    .doe       (sdata_oe),
    .bit_cnt   (bit_cnt)
  );

  sio3_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (reg_addr),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .xdcr_q   (xdcr_q),
    .gctl_q   (gctl_q),
    .srst_evt (srst_evt)
  );

  assign sdata2_oe   = 1'b0;
  assign mic_en      = xdcr_q[XDCR_MIC_EN];
  assign mic_sel     = xdcr_q[XDCR_MIC_SEL];
  assign hspk_en     = xdcr_q[XDCR_HSPK_EN];
  assign lspk_en     = xdcr_q[XDCR_LSPK_EN];
  assign tx_gain_sel = gctl_q[GCTL_TXG];
  assign rx_gain_sel = gctl_q[GCTL_RXG];

endmodule

// File: rtl/sio3_reg_port_chk.sv
module sio3_reg_port_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_act,
  input logic             sclk_fall,
  input logic             sdata_oe,
  input logic             sdata_out,
  input logic             wr_en,
  input logic             srst_evt,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             mic_en,
  input logic             mic_sel,
  input logic             hspk_en,
  input logic             lspk_en,
  input logic             tx_gain_sel,
  input logic             rx_gain_sel
);

  assert_oe_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !sdata_oe);

  assert_dout_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata_oe && !sclk_fall) |=> $stable(sdata_out));

  assert_oe_after_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdata_oe) |-> (bit_cnt == CNT_W'(DATA_W)));

  assert_write_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (bit_cnt == CNT_W'(2*DATA_W)));

  assert_no_write_unselected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |-> !wr_en);

  assert_cnt_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(2*DATA_W));

  assert_srst_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    srst_evt |=> !(mic_en || mic_sel || hspk_en || lspk_en || tx_gain_sel || rx_gain_sel));

endmodule

bind sio3_reg_port sio3_reg_port_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_act      (cs_act),
  .sclk_fall   (sclk_fall),
  .sdata_oe    (sdata_oe),
  .sdata_out   (sdata_out),
  .wr_en       (wr_en),
  .srst_evt    (srst_evt),
  .bit_cnt     (bit_cnt),
  .mic_en      (mic_en),
  .mic_sel     (mic_sel),
  .hspk_en     (hspk_en),
  .lspk_en     (lspk_en),
  .tx_gain_sel (tx_gain_sel),
  .rx_gain_sel (rx_gain_sel)
);

// File: tb/sio3_reg_port_tb.sv
module sio3_reg_port_tb;

  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b1;
  logic host_bit = 1'b1;
  wire  line;
  logic sdata_out, sdata_oe, sdata2_oe;
  logic mic_en, mic_sel, hspk_en, lspk_en, tx_gain_sel, rx_gain_sel;

  assign line = sdata_oe ? sdata_out : host_bit;

  sio3_reg_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdata_in(line),
    .sdata_out(sdata_out), .sdata_oe(sdata_oe), .sdata2_oe(sdata2_oe),
    .mic_en(mic_en), .mic_sel(mic_sel), .hspk_en(hspk_en), .lspk_en(lspk_en),
    .tx_gain_sel(tx_gain_sel), .rx_gain_sel(rx_gain_sel)
  );

  always #5 clk = ~clk;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   cmp_ok = 1'b0;
  bit   exp_oe = 1'b0;
  bit   exp_dout = 1'b0;
  logic [7:0] mem [32];
  logic [7:0] rv;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=0x%0h exp=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model compared on every clock once inputs have settled
  always @(negedge clk) begin
    if (cmp_ok) begin
      chk(sdata_oe === exp_oe, "R4 oe", int'(sdata_oe), int'(exp_oe));
      if (exp_oe) chk(sdata_out === exp_dout, "R3 dout", int'(sdata_out), int'(exp_dout));
      chk({lspk_en, hspk_en, mic_sel, mic_en} === mem[14][3:0], "R6 xdcr",
          int'({lspk_en, hspk_en, mic_sel, mic_en}), int'(mem[14][3:0]));
      chk({rx_gain_sel, tx_gain_sel} === mem[15][1:0], "R7 gain",
          int'({rx_gain_sel, tx_gain_sel}), int'(mem[15][1:0]));
      chk(sdata2_oe === 1'b0, "R9 data2", int'(sdata2_oe), 0);
    end
  end

  task automatic settle();
    cmp_ok = 1'b0;
    repeat (6) @(posedge clk);
    #1 cmp_ok = 1'b1;
    repeat (HALF - 6) @(posedge clk);
    #1 cmp_ok = 1'b0;
  endtask

  task automatic model_write(input int a, input logic [7:0] d);
    if (a == 15 && d[7]) begin
      for (int k = 0; k < 32; k++) mem[k] = 8'h00;
    end else begin
      mem[a] = d;
    end
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [7:0] wdata,
                      input int nbits, input int extra, output logic [7:0] rdv);
    bit rd;
    int a;
    logic [7:0] rb;
    rd  = cmd[7];
    a   = int'(cmd[4:0]);
    rb  = 8'h00;
    rdv = 8'h00;
    cs_n = 1'b0;
    settle();
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      host_bit = (i < 8) ? cmd[i] : (rd ? 1'b1 : wdata[i-8]);
      if (rd && i == 8) begin
        exp_oe = 1'b1;
        rb = mem[a];
        exp_dout = rb[0];
      end else if (rd && i > 8) begin
        exp_dout = rb[i-8];
      end
      settle();
      if (rd && i >= 8) rdv[i-8] = line;
      sclk = 1'b1;
      if (!rd && i == 15) model_write(a, wdata);
      settle();
    end
    for (int e = 0; e < extra; e++) begin
      sclk = 1'b0;
      host_bit = ~host_bit;
      exp_oe = 1'b0;
      settle();
      sclk = 1'b1;
      settle();
    end
    cs_n = 1'b1;
    host_bit = 1'b1;
    exp_oe = 1'b0;
    settle();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog: act=timeout exp=completion");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 32; k++) mem[k] = 8'h00;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    settle();
    // R9: reset state
    chk({mic_en, mic_sel, hspk_en, lspk_en, tx_gain_sel, rx_gain_sel} == 6'b0, "R9 ctrl reset",
        int'({mic_en, mic_sel, hspk_en, lspk_en, tx_gain_sel, rx_gain_sel}), 0);
    chk(sdata_oe == 1'b0, "R9 oe reset", int'(sdata_oe), 0);
    chk(sdata2_oe == 1'b0, "R9 data2 reset", int'(sdata2_oe), 0);
    xfer(8'h9E, 8'h00, 16, 0, rv);
    chk(rv == 8'h00, "R9 reg reset", int'(rv), 0);

    // R6 / R7: control registers
    xfer(8'h0E, 8'h0B, 16, 0, rv);
    chk({lspk_en, hspk_en, mic_sel, mic_en} == 4'b1011, "R6 xdcr bits",
        int'({lspk_en, hspk_en, mic_sel, mic_en}), 'hB);
    xfer(8'h0F, 8'h02, 16, 0, rv);
    chk(rx_gain_sel == 1'b1 && tx_gain_sel == 1'b0, "R7 gain bits",
        int'({rx_gain_sel, tx_gain_sel}), 2);

    // R3: read back
    xfer(8'h8E, 8'h00, 16, 0, rv);
    chk(rv == 8'h0B, "R3 read xdcr", int'(rv), 'h0B);

    // R2: write/read across the map
    xfer(8'h15, 8'hA5, 16, 0, rv);
    xfer(8'h95, 8'h00, 16, 0, rv);
    chk(rv == 8'hA5, "R2 reg 0x15", int'(rv), 'hA5);
    xfer(8'h00, 8'h5A, 16, 0, rv);
    xfer(8'h80, 8'h00, 16, 0, rv);
    chk(rv == 8'h5A, "R2 reg 0x00", int'(rv), 'h5A);
    xfer(8'h1F, 8'hC3, 16, 0, rv);
    xfer(8'h9F, 8'h00, 16, 0, rv);
    chk(rv == 8'hC3, "R2 reg 0x1F", int'(rv), 'hC3);

    // R1: unused command bits 6:5 ignored
    xfer(8'h6E, 8'h04, 16, 0, rv);
    xfer(8'hEE, 8'h00, 16, 0, rv);
    chk(rv == 8'h04, "R1 masked addr", int'(rv), 'h04);
    chk(hspk_en == 1'b1 && mic_en == 1'b0, "R1 decode", int'({hspk_en, mic_en}), 2);

    // R5: aborts in data and in command
    xfer(8'h0E, 8'h00, 12, 0, rv);
    xfer(8'h8E, 8'h00, 16, 0, rv);
    chk(rv == 8'h04, "R5 abort in data", int'(rv), 'h04);
    xfer(8'h0E, 8'h00, 5, 0, rv);
    xfer(8'h03, 8'h11, 16, 0, rv);
    xfer(8'h83, 8'h00, 16, 0, rv);
    chk(rv == 8'h11, "R5 counter restart", int'(rv), 'h11);

    // R4: abort inside read data
    xfer(8'h95, 8'h00, 11, 0, rv);
    chk(sdata_oe == 1'b0, "R4 release on deselect", int'(sdata_oe), 0);

    // R10: surplus clocks
    xfer(8'h03, 8'h3C, 16, 5, rv);
    xfer(8'h83, 8'h00, 16, 3, rv);
    chk(rv == 8'h3C, "R10 extra clocks", int'(rv), 'h3C);

    // R8: software reset, first on another register then on its own
    xfer(8'h0E, 8'h80, 16, 0, rv);
    xfer(8'h8E, 8'h00, 16, 0, rv);
    chk(rv == 8'h80, "R8 bit7 elsewhere", int'(rv), 'h80);
    xfer(8'h0F, 8'h83, 16, 0, rv);
    chk({mic_en, mic_sel, hspk_en, lspk_en, tx_gain_sel, rx_gain_sel} == 6'b0, "R8 ctrl cleared",
        int'({mic_en, mic_sel, hspk_en, lspk_en, tx_gain_sel, rx_gain_sel}), 0);
    xfer(8'h8F, 8'h00, 16, 0, rv);
    chk(rv == 8'h00, "R8 gctl cleared", int'(rv), 0);
    xfer(8'h95, 8'h00, 16, 0, rv);
    chk(rv == 8'h00, "R8 others cleared", int'(rv), 0);

    finish_run();
  end

endmodule